// File: doc/BRIEF.md
# Per-Timeslot Channel Control Datapath

This block applies a separate control word to each of the 32 byte-wide timeslots of a TDM frame. It sits between a backplane side and a PCM line side and handles both directions. In the transmit direction it picks which byte goes onto the line. In the receive direction it picks which byte goes back to the backplane.

For every timeslot, the framing logic around the block presents the following bytes, together with a timeslot index and a one-cycle `slot_start` strobe:
- the backplane transmit byte,
- the line receive byte,
- the byte from the transmit message buffer,
- two test-pattern bytes.

At the strobe, the block reads the stored control word for that slot. From it the block applies alternate-bit inversion, local or remote loopback, message substitution or test substitution. It registers both result bytes, and they are held for the whole of the next timeslot.

The 32 control words are written and read back through a register port that takes a page number and an address. One page covers slots 0–15 and a second page covers slots 16–31. In each page the slots sit at addresses 0x10–0x1F.

Top module: `tslot_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `line_tx`, `bp_rx` and `out_slot` are 0, and every control word reads back as 0x00.
- R2: A write to page 0 at address 0x10+k (k = 0..15) sets the control word of slot k. A write to page 1 at address 0x10+k sets the control word of slot 16+k. `reg_rdata` returns the full stored byte for such an address in the same cycle.
- R3: Any read outside the two pages or outside addresses 0x10–0x1F returns 0x00. Any write there changes no control word.
- R4: With a control word of 0x00, `line_tx` equals the backplane transmit byte and `bp_rx` equals the line receive byte.
- R5: When bit 7 is 1 (message select), `line_tx` is the `msg_byte` given for that slot.
- R6: When bit 6 is 1 (alternate inversion), the backplane transmit byte is XORed with 0x55 before it goes to the line, and the line receive byte is XORed with 0x55 before it goes to the backplane.
- R7: When bit 5 is 1 (remote loopback), `line_tx` is the unmodified line receive byte. `bp_rx` still carries the line receive byte, inverted if bit 6 is set.
- R8: When bit 4 is 1 (local loopback), `bp_rx` is the unmodified backplane transmit byte. `line_tx` still carries the normal transmit byte.
- R9: When both loopbacks are set, remote loopback decides `line_tx` and local loopback decides `bp_rx`. Remote loopback also takes priority over message select.
- R10: When bit 3 is set, `test_tx_byte` replaces `line_tx`. When bit 2 is set, `test_rx_byte` replaces `bp_rx`. Each replacement overrides every other selection in its direction.
- R11: Bits 1 and 0 are stored and read back but do not change either output byte.
- R12: The results for the slot captured at a `slot_start` edge appear after that edge, with `out_slot` equal to the captured index. They are held unchanged until the next `slot_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_page | input | 8 | Register page number |
| reg_addr | input | 8 | Register address within the page |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data (combinational) |
| slot_start | input | 1 | One-cycle strobe at the start of a timeslot |
| slot_idx | input | 5 | Index of the timeslot being presented |
| bp_tx_byte | input | 8 | Backplane transmit byte for the slot |
| line_rx_byte | input | 8 | Line receive byte for the slot |
| msg_byte | input | 8 | Transmit message buffer byte for the slot |
| test_tx_byte | input | 8 | Test-pattern byte for the line transmit side |
| test_rx_byte | input | 8 | Test-pattern byte for the backplane output side |
| line_tx | output | 8 | Line transmit byte, delayed one timeslot |
| bp_rx | output | 8 | Backplane output byte, delayed one timeslot |
| out_slot | output | 5 | Index of the slot whose bytes are on the outputs |

## Verification
The bound checker checks several behaviours on every cycle:
- the outputs hold between strobes,
- `out_slot` matches the index captured at the strobe,
- reads outside the decoded window return zero,
- a write to a decoded address is seen on the following read,
- the outputs are zero during reset.

The per-slot choice of output byte needs the stored word and the presented bytes together, so only the bench scenarios can show it. These scenarios cover the message, inversion, loopback, priority, test-override and unused-bit cases, in slots that span both pages. They also cover writes to addresses next to the decoded window.

// File: rtl/tslot_ctrl.sv
module tslot_ctrl #(
  parameter int          SLOTS   = 32,
  parameter int          DW      = 8,
  parameter logic [7:0]  PAGE_LO = 8'h00,
  parameter logic [7:0]  PAGE_HI = 8'h01,
  parameter logic [7:0]  BASE    = 8'h10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [7:0]                 reg_page,
  input  logic [7:0]                 reg_addr,
  input  logic [7:0]                 reg_wdata,
  output logic [7:0]                 reg_rdata,
  input  logic                       slot_start,
  input  logic [$clog2(SLOTS)-1:0]   slot_idx,
  input  logic [DW-1:0]              bp_tx_byte,
  input  logic [DW-1:0]              line_rx_byte,
  input  logic [DW-1:0]              msg_byte,
  input  logic [DW-1:0]              test_tx_byte,
  input  logic [DW-1:0]              test_rx_byte,
  output logic [DW-1:0]              line_tx,
  output logic [DW-1:0]              bp_rx,
  output logic [$clog2(SLOTS)-1:0]   out_slot
);
  localparam int SW   = $clog2(SLOTS);
  localparam int HALF = SLOTS / 2;
  localparam int B_MSG = 7, B_ADI = 6, B_RLB = 5, B_LLB = 4, B_TTX = 3, B_TRX = 2;

  function automatic logic [DW-1:0] alt_mask();
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i % 2 == 0);
    return m;
  endfunction
  localparam logic [DW-1:0] ADI_MASK = alt_mask();

  logic [7:0] cw_mem [SLOTS];

  logic [7:0]    off;
  logic          in_win, hit_lo, hit_hi, hit;
  logic [SW-1:0] reg_idx;

  assign off     = reg_addr - BASE;
  assign in_win  = (reg_addr >= BASE) && ({1'b0, off} < 9'(HALF));
  assign hit_lo  = in_win && (reg_page == PAGE_LO);
  assign hit_hi  = in_win && (reg_page == PAGE_HI);
  assign hit     = hit_lo || hit_hi;
  assign reg_idx = SW'(off) + (hit_hi ? SW'(HALF) : SW'(0));
  assign reg_rdata = hit ? cw_mem[reg_idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) cw_mem[i] <= 8'h00;
    end else if (reg_we && hit) begin
      cw_mem[reg_idx] <= reg_wdata;
    end
  end

  logic [7:0]    cw;
  logic [DW-1:0] mask, tx_norm, rx_norm, ltx_nx, brx_nx;

  assign cw      = cw_mem[slot_idx];
  assign mask    = cw[B_ADI] ? ADI_MASK : '0;
  assign tx_norm = bp_tx_byte ^ mask;
  assign rx_norm = line_rx_byte ^ mask;

  always_comb begin
    if (cw[B_TTX])      ltx_nx = test_tx_byte;
    else if (cw[B_RLB]) ltx_nx = line_rx_byte;
    else if (cw[B_MSG]) ltx_nx = msg_byte;
    else                ltx_nx = tx_norm;
  end

  always_comb begin
    if (cw[B_TRX])      brx_nx = test_rx_byte;
    else if (cw[B_LLB]) brx_nx = bp_tx_byte;
    else                brx_nx = rx_norm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_tx  <= '0;
      bp_rx    <= '0;
      out_slot <= '0;
    end else if (slot_start) begin
      line_tx  <= ltx_nx;
      bp_rx    <= brx_nx;
      out_slot <= slot_idx;
    end
  end
endmodule

module tslot_ctrl_chk #(
  parameter int          SLOTS   = 32,
  parameter int          DW      = 8,
  parameter logic [7:0]  PAGE_LO = 8'h00,
  parameter logic [7:0]  PAGE_HI = 8'h01,
  parameter logic [7:0]  BASE    = 8'h10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_we,
  input logic [7:0]               reg_page,
  input logic [7:0]               reg_addr,
  input logic [7:0]               reg_wdata,
  input logic [7:0]               reg_rdata,
  input logic                     slot_start,
  input logic [$clog2(SLOTS)-1:0] slot_idx,
  input logic [DW-1:0]            line_tx,
  input logic [DW-1:0]            bp_rx,
  input logic [$clog2(SLOTS)-1:0] out_slot
);
  logic decoded;
  assign decoded = (reg_page == PAGE_LO || reg_page == PAGE_HI) &&
                   (reg_addr >= BASE) && (int'(reg_addr) < int'(BASE) + SLOTS / 2);

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> ($stable(line_tx) && $stable(bp_rx) && $stable(out_slot)));

  // R12
  slot_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> (out_slot == $past(slot_idx)));

  // R3
  undecoded_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !decoded |-> (reg_rdata == 8'h00));

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_we) && !reg_we && decoded && $stable(reg_page) && $stable(reg_addr))
      |-> (reg_rdata == $past(reg_wdata)));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (line_tx == '0 && bp_rx == '0 && out_slot == '0));
endmodule

bind tslot_ctrl tslot_ctrl_chk #(.SLOTS(SLOTS), .DW(DW), .PAGE_LO(PAGE_LO),
                                 .PAGE_HI(PAGE_HI), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_page(reg_page),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .slot_start(slot_start), .slot_idx(slot_idx), .line_tx(line_tx),
  .bp_rx(bp_rx), .out_slot(out_slot)
);

// File: tb/tb_tslot_ctrl.sv
module tb_tslot_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_we = 0;
  logic [7:0] reg_page = 0, reg_addr = 0, reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       slot_start = 0;
  logic [4:0] slot_idx = 0;
  logic [7:0] bp_tx_byte = 0, line_rx_byte = 0, msg_byte = 0, test_tx_byte = 0, test_rx_byte = 0;
  logic [7:0] line_tx, bp_rx;
  logic [4:0] out_slot;

  int checks = 0, errors = 0;
  logic [7:0] cw_model [32];
  logic [20:0] exp_q [$];
  string       tag_q [$];
  logic        pending = 0;

  always #5 clk = ~clk;

  tslot_ctrl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [7:0] c);
    if (c[3] || c[2]) return "R10";
    if (c[5] && c[4]) return "R9";
    if (c[5])         return "R7";
    if (c[4])         return "R8";
    if (c[7])         return "R5";
    if (c[6])         return "R6";
    if (c[1:0] != 0)  return "R11";
    return "R4";
  endfunction

  task automatic wr(logic [7:0] pg, logic [7:0] ad, logic [7:0] d);
    @(posedge clk); #2;
    reg_we = 1; reg_page = pg; reg_addr = ad; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0;
    if (ad >= 8'h10 && ad < 8'h20 && pg <= 8'h01)
      cw_model[{pg[0], ad[3:0]}] = d;
  endtask

  task automatic rd(string req, logic [7:0] pg, logic [7:0] ad, logic [7:0] exp);
    reg_page = pg; reg_addr = ad; #1;
    check(req, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  task automatic drive_slot(logic [4:0] s, int f);
    logic [7:0] c, bp, lr, mg, tt, tr, ltx, brx, m;
    bp = 8'(s * 7 + f * 49) ^ 8'hA0;
    lr = 8'(s * 13) ^ 8'h3C ^ 8'(f * 17);
    mg = 8'hC3 ^ {3'b0, s};
    tt = 8'h90 + 8'(s);
    tr = 8'h60 + 8'(s) + 8'(f);
    c  = cw_model[s];
    m  = c[6] ? 8'h55 : 8'h00;
    // R9 R10: test override first, remote over message on line side, local on backplane side
    ltx = c[3] ? tt : c[5] ? lr : c[7] ? mg : (bp ^ m);
    brx = c[2] ? tr : c[4] ? bp : (lr ^ m);
    @(posedge clk); #2;
    slot_start = 1; slot_idx = s;
    bp_tx_byte = bp; line_rx_byte = lr; msg_byte = mg; test_tx_byte = tt; test_rx_byte = tr;
    exp_q.push_back({s, ltx, brx});
    tag_q.push_back(req_of(c));
    @(posedge clk); #2;
    slot_start = 0;
    bp_tx_byte = 8'hFF; line_rx_byte = 8'hFF;
  endtask

  // monitor: compare each result one negedge after the capturing edge
  always @(negedge clk) begin
    if (pending) begin
      logic [20:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " line_tx"}, {24'h0, line_tx}, {24'h0, e[15:8]});
      check({t, " bp_rx"},   {24'h0, bp_rx},   {24'h0, e[7:0]});
      check("R12 out_slot",  {27'h0, out_slot}, {27'h0, e[20:16]});
      pending = 0;
    end
    if (slot_start && rst_n) pending = 1;
  end

  logic done = 0;
  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) cw_model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 line_tx", {24'h0, line_tx}, 0);
    check("R1 bp_rx", {24'h0, bp_rx}, 0);
    rst_n = 1;
    @(posedge clk); #2;
    check("R1 out_slot", {27'h0, out_slot}, 0);
    rd("R1", 8'h00, 8'h10, 8'h00);
    rd("R1", 8'h01, 8'h1F, 8'h00);

    // R2 configuration across both pages
    wr(8'h00, 8'h11, 8'h80);
    wr(8'h00, 8'h12, 8'h40);
    wr(8'h00, 8'h13, 8'h20);
    wr(8'h00, 8'h14, 8'h10);
    wr(8'h00, 8'h15, 8'h30);
    wr(8'h00, 8'h16, 8'h08);
    wr(8'h00, 8'h17, 8'h04);
    wr(8'h00, 8'h18, 8'h03);
    wr(8'h00, 8'h19, 8'h70);
    wr(8'h00, 8'h1A, 8'hC4);
    wr(8'h00, 8'h1B, 8'hA8);
    wr(8'h01, 8'h11, 8'hC0);
    wr(8'h01, 8'h1F, 8'h70);
    wr(8'h01, 8'h10, 8'h60);
    // R3 undecoded writes must not land anywhere
    wr(8'h00, 8'h0F, 8'hFF);
    wr(8'h00, 8'h20, 8'hFF);
    wr(8'h02, 8'h10, 8'hFF);
    wr(8'h07, 8'h1F, 8'hFF);

    rd("R2", 8'h00, 8'h11, 8'h80);
    rd("R2 R11", 8'h00, 8'h18, 8'h03);
    rd("R2", 8'h01, 8'h11, 8'hC0);
    rd("R2", 8'h01, 8'h1F, 8'h70);
    rd("R3", 8'h00, 8'h10, 8'h00);
    rd("R3", 8'h01, 8'h1E, 8'h00);
    rd("R3", 8'h00, 8'h0F, 8'h00);
    rd("R3", 8'h02, 8'h10, 8'h00);
    rd("R3", 8'h00, 8'h20, 8'h00);

    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 32; s++) drive_slot(5'(s), f);

    // rewrite one slot and re-run: change takes effect for the next frame
    wr(8'h00, 8'h10, 8'h50);
    rd("R2", 8'h00, 8'h10, 8'h50);
    for (int s = 0; s < 32; s++) drive_slot(5'(s), 3);

    repeat (4) @(posedge clk);
    check("R12 queue drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule